// File: doc/BRIEF.md
# SDRAM Command Sequencer with Open-Row Tracking

This block turns single-word read and write requests from a system bus into SDRAM command cycles on a 32-bit data path. It keeps one open row per bank and checks every request against it. A request to a bank with no open row opens the row first. A request to a bank whose open row is a different one closes that row, waits, and then opens the wanted row. A request that hits the open row goes straight to its column command.

Writes are issued one word at a time. Each WRITE command carries its own column address and data word, so the sequencer never relies on the memory's internal burst counter. A run of same-row writes therefore fills every command cycle. A write run ends simply because no further WRITE is issued. A single read is cut to one word by a burst-terminate command in the cycle after the READ. The returned word is captured CAS-latency cycles after the memory takes the READ.

The requester presents `req_valid` with its address, direction and write data, and holds them until `req_ack` is high in a cycle. The word transfers at the clock edge that ends that cycle. Read data follows one cycle later as a one-cycle `rd_valid` pulse.

Top module: `sdram_seq_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows NOP, `req_ack` and `rd_valid` low, and every bank is marked closed, so the first access to any bank after reset issues ACTIVE and never PRECHARGE.
- R2: Commands appear on {`sd_cs_n`, `sd_ras_n`, `sd_cas_n`, `sd_we_n`} as NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, BURST TERMINATE=0110.
- R3: `req_addr` is split as {row[11:0], bank[1:0], column[7:0]} from the top bit down. ACTIVE drives the row on `sd_addr`. READ and WRITE drive the column, zero-extended, on `sd_addr`. Every command that targets a bank drives that bank on `sd_ba`.
- R4: A request to a closed bank issues ACTIVE in the first cycle after it is presented, and its column command exactly T_RCD cycles after that ACTIVE, with only NOP in between.
- R5: A request to a bank whose open row differs issues PRECHARGE with `sd_addr` bit 10 low (one bank only) in the first cycle after it is presented. It issues ACTIVE exactly T_RP cycles later and the column command T_RCD cycles after that, with only NOP in between.
- R6: A request that hits the open row of its bank issues its column command in the first cycle after it is presented, with no ACTIVE or PRECHARGE.
- R7: A READ is followed in the next cycle by BURST TERMINATE and then by NOP. The data on `sd_dq_in` is captured CAS_LAT cycles after the cycle in which the READ is on the pins. It is presented on `rd_data` with a one-cycle `rd_valid` pulse in the cycle after that capture.
- R8: A write word appears on `sd_dq_out` with `sd_dq_oe` high in the same cycle as its WRITE command and column address. `sd_dq_oe` is low in every other cycle.
- R9: Same-row writes presented back to back produce a WRITE in every consecutive cycle, each with its own column and data. BURST TERMINATE never follows a WRITE; the cycle after the last WRITE is NOP.
- R10: `req_ack` is high for exactly one cycle per word. For a write it is high in the cycle before the WRITE appears on the pins. For a read it is high in the cycle before `rd_valid`.
- R11: Each bank keeps its open row independently. Opening or closing a row in one bank does not change the hit or miss outcome of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the SDRAM |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {row, bank, column} |
| req_wdata | input | 32 | Write data word |
| req_ack | output | 1 | Word transfers at the end of this cycle |
| rd_data | output | 32 | Returned read word |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Row or column address |
| sd_dq_out | output | 32 | Data driven to the memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 32 | Data returned by the memory |

## Verification
The assertions assume that a requester keeps `req_valid`, `req_write`, `req_addr` and `req_wdata` unchanged from the cycle it raises `req_valid` until the cycle `req_ack` is high. They also assume the timing parameters are at least one cycle. The stimulus changes request fields only at the falling clock edge. It holds a request until it sees the acknowledge, then withdraws or replaces it in the next cycle. Random addresses are confined to a few rows per bank so that hits, closed-bank misses and row conflicts all occur often.

// File: rtl/sdseq_pkg.sv
// Package: shared command encoding and sequencer states.
// Assumes the command is driven as {cs_n, ras_n, cas_n, we_n}.
package sdseq_pkg;

    typedef enum logic [3:0] {
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_TBST  = 4'b0110,
        CMD_NOP   = 4'b0111
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE_WAIT,
        ST_ACT_WAIT,
        ST_RD_WAIT
    } seq_state_e;

endpackage

// File: rtl/sdseq_row_table.sv
// Open-row table: one row register and one open flag per bank.
// Looks up the requested bank combinationally.
// Assumes open and close requests never arrive in the same cycle.
module sdseq_row_table #(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 12,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    input  logic              open_en,
    input  logic              close_en,
    output logic              is_open,
    output logic              is_hit
);

    logic [BANKS-1:0]            vld_all;
    logic [BANKS-1:0][ROW_W-1:0] row_all;

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic             vld_r;
            logic [ROW_W-1:0] row_r;

            // Track the open row of this bank; reset marks it closed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_r <= 1'b0;
                    row_r <= '0;
                end else if (open_en && look_bank == BANK_W'(b)) begin
                    vld_r <= 1'b1;
                    row_r <= look_row;
                end else if (close_en && look_bank == BANK_W'(b)) begin
                    vld_r <= 1'b0;
                end
            end

            assign vld_all[b] = vld_r;
            assign row_all[b] = row_r;
        end
    endgenerate

    // Compare the requested row with the stored row of its bank.
    always_comb begin
        is_open = vld_all[look_bank];
        is_hit  = is_open && (row_all[look_bank] == look_row);
    end

    // R5
    open_close_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_en && close_en));

    // R4
    open_only_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |-> !is_open);

endmodule

// File: rtl/sdseq_wait_timer.sv
// Down-counter for the command spacing waits (row-to-column,
// precharge-to-activate, CAS latency).
// Assumes it is loaded only once the previous wait has run out.
module sdseq_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    // Load a new wait or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R4
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero);

endmodule

// File: rtl/sdram_seq_core.sv
// SDRAM command sequencer with per-bank open-row tracking.
// Turns held single-word requests into PRECHARGE / ACTIVE /
// READ+BURST TERMINATE / WRITE sequences. All pin outputs are registered.
// Assumes: requests stay stable until req_ack; T_RCD, T_RP, CAS_LAT >= 1;
// COL_W <= ROW_W and ROW_W >= 11 so that address bit 10 exists.
module sdram_seq_core
    import sdseq_pkg::*;
#(
    parameter int ROW_W   = 12,
    parameter int COL_W   = 8,
    parameter int BANKS   = 4,
    parameter int DATA_W  = 32,
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int CAS_LAT = 2,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);

    localparam int MAX_A = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAX_W = (MAX_A > CAS_LAT) ? MAX_A : CAS_LAT;
    localparam int CNT_W = $clog2(MAX_W + 1);

    logic [COL_W-1:0]  req_col;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;

    seq_state_e        state;
    sd_cmd_e           cmd_q;
    logic              is_open, is_hit;
    logic              t_load, t_zero;
    logic [CNT_W-1:0]  t_val, t_cnt;
    logic              do_pre, do_act, col_go, rd_done;

    // Split the word address into row, bank and column.
    always_comb begin
        req_col  = req_addr[COL_W-1:0];
        req_bank = req_addr[COL_W +: BANK_W];
        req_row  = req_addr[COL_W+BANK_W +: ROW_W];
    end

    sdseq_row_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_bank(req_bank),
        .look_row (req_row),
        .open_en  (do_act),
        .close_en (do_pre),
        .is_open  (is_open),
        .is_hit   (is_hit)
    );

    sdseq_wait_timer #(.CNT_W(CNT_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .load_val(t_val),
        .cnt     (t_cnt),
        .zero    (t_zero)
    );

    // Decide which command, if any, the next edge issues.
    always_comb begin
        do_pre  = req_valid && state == ST_IDLE && is_open && !is_hit;
        do_act  = req_valid && ((state == ST_IDLE && !is_open) ||
                                (state == ST_PRE_WAIT && t_zero));
        col_go  = req_valid && ((state == ST_IDLE && is_hit) ||
                                (state == ST_ACT_WAIT && t_zero));
        rd_done = state == ST_RD_WAIT && t_zero;
        req_ack = (col_go && req_write) || rd_done;
    end

    // Pick the wait loaded with each command that needs spacing.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (do_pre) begin
            t_load = 1'b1;
            t_val  = CNT_W'(T_RP - 1);
        end else if (do_act) begin
            t_load = 1'b1;
            t_val  = CNT_W'(T_RCD - 1);
        end else if (col_go && !req_write) begin
            t_load = 1'b1;
            t_val  = CNT_W'(CAS_LAT);
        end
    end

    // Register the pins, advance the state and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cmd_q     <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            cmd_q    <= CMD_NOP;
            sd_dq_oe <= 1'b0;
            rd_valid <= 1'b0;
            if (do_pre) begin
                cmd_q   <= CMD_PRE;
                sd_ba   <= req_bank;
                sd_addr <= '0;
                state   <= ST_PRE_WAIT;
            end else if (do_act) begin
                cmd_q   <= CMD_ACT;
                sd_ba   <= req_bank;
                sd_addr <= req_row;
                state   <= ST_ACT_WAIT;
            end else if (col_go) begin
                sd_ba   <= req_bank;
                sd_addr <= ROW_W'(req_col);
                if (req_write) begin
                    cmd_q     <= CMD_WRITE;
                    sd_dq_out <= req_wdata;
                    sd_dq_oe  <= 1'b1;
                    state     <= ST_IDLE;
                end else begin
                    cmd_q <= CMD_READ;
                    state <= ST_RD_WAIT;
                end
            end else if (state == ST_RD_WAIT) begin
                if (t_zero) begin
                    rd_data  <= sd_dq_in;
                    rd_valid <= 1'b1;
                    state    <= ST_IDLE;
                end else if (t_cnt == CNT_W'(CAS_LAT)) begin
                    cmd_q <= CMD_TBST;
                end
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

    // R7
    read_then_tbst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q == CMD_READ |=> cmd_q == CMD_TBST);

    // R9
    no_tbst_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q == CMD_WRITE |=> cmd_q != CMD_TBST);

    // R7
    rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R5
    pre_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (T_RP > 1 && cmd_q == CMD_PRE) |=> cmd_q == CMD_NOP);

    // R4
    act_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (T_RCD > 1 && cmd_q == CMD_ACT) |=> cmd_q == CMD_NOP);

    // R6
    col_needs_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_go |-> is_hit);

    // R10
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

endmodule

// File: tb/sdram_seq_core_test.sv
// Self-checking bench: a small SDRAM model answers the pins, and a
// bench-side row table and memory predict every command and data word.
module sdram_seq_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int RCD = 2;
    localparam int RP  = 2;
    localparam int CL  = 2;

    // R2 encodings, {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_TB = 4'b0110, C_PRE = 4'b0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ack, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [31:0] rd_data, sd_dq_out, sd_dq_in;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;

    int checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_seq_core #(.T_RCD(RCD), .T_RP(RP), .CAS_LAT(CL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

    wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // ---- SDRAM model on the pins ----
    logic [31:0] mem_arr [int];
    logic [11:0] mod_row [4];
    logic [31:0] rpipe [CL];
    assign sd_dq_in = rpipe[CL-1];

    function automatic logic [31:0] fill(int key);
        return 32'hC0DE0000 ^ key;
    endfunction

    always @(posedge clk) begin
        int key;
        key = {sd_ba, mod_row[sd_ba], sd_addr[7:0]};
        if (cmd == C_ACT) mod_row[sd_ba] = sd_addr;
        if (cmd == C_WR && sd_dq_oe) mem_arr[key] = sd_dq_out;
        for (int i = CL-1; i > 0; i--) rpipe[i] <= rpipe[i-1];
        rpipe[0] <= (cmd == C_RD) ? (mem_arr.exists(key) ? mem_arr[key] : fill(key)) : 32'h0;
    end

    // ---- bench prediction state ----
    logic [31:0] exp_mem [int];
    logic        b_open [4];
    logic [11:0] b_row  [4];

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: idle outputs during reset
        chk(cmd == C_NOP, "R1 reset cmd", 32'(cmd), 32'(C_NOP));
        chk(!req_ack && !rd_valid, "R1 reset ack/rd_valid", {30'd0, req_ack, rd_valid}, 0);
        chk(!sd_dq_oe, "R1 reset oe", 32'(sd_dq_oe), 0);
        for (int b = 0; b < 4; b++) b_open[b] = 1'b0;
        rst_n = 1'b1;
    endtask

    // One request, predicted cycle by cycle. Caller is at a falling edge.
    task automatic run_req(input bit wr, input logic [1:0] bank, input logic [11:0] row,
                           input logic [7:0] col, input logic [31:0] data);
        int c, ka, klast, kind, key;
        logic [3:0] ecmd;
        logic [31:0] edat;
        key = {bank, row, col};
        // kind: 0 hit (R6), 1 closed bank (R4), 2 row conflict (R5)
        if (b_open[bank] && b_row[bank] == row) kind = 0;
        else if (!b_open[bank]) kind = 1;
        else kind = 2;
        c = (kind == 0) ? 1 : (kind == 1) ? 1 + RCD : 1 + RP + RCD;
        ka = wr ? c - 1 : c + CL;
        klast = wr ? c + 1 : c + CL + 2;
        edat = exp_mem.exists(key) ? exp_mem[key] : fill(key);
        req_valid = 1'b1; req_write = wr; req_addr = {row, bank, col}; req_wdata = data;
        for (int k = 0; k <= klast; k++) begin
            if (k > 0) @(negedge clk);
            if (k == ka + 1) req_valid = 1'b0;
            #1;
            // R10 one acknowledge at the predicted cycle
            chk(req_ack == (k == ka), "R10 ack timing", 32'(req_ack), 32'(k == ka));
            if (k == 0) continue;
            ecmd = C_NOP;
            if (kind == 1 && k == 1) ecmd = C_ACT;
            if (kind == 2 && k == 1) ecmd = C_PRE;
            if (kind == 2 && k == 1 + RP) ecmd = C_ACT;
            if (k == c) ecmd = wr ? C_WR : C_RD;
            if (!wr && k == c + 1) ecmd = C_TB;   // R7 terminate after read
            chk(cmd == ecmd, wr ? "R9 R4 R5 R6 write cmd sequence" : "R7 R4 R5 R6 read cmd sequence",
                32'(cmd), 32'(ecmd));
            if (ecmd == C_ACT) begin
                chk(sd_addr == row && sd_ba == bank, "R3 activate row/bank",
                    {18'd0, sd_ba, sd_addr}, {18'd0, bank, row});
            end
            if (ecmd == C_PRE) begin
                chk(sd_addr[10] == 1'b0 && sd_ba == bank, "R5 precharge single bank",
                    {19'd0, sd_addr[10], 10'd0, sd_ba}, {30'd0, bank});
            end
            if (k == c) begin
                chk(sd_addr == {4'd0, col} && sd_ba == bank, "R3 column addr/bank",
                    {18'd0, sd_ba, sd_addr}, {18'd0, bank, 4'd0, col});
            end
            // R8 data only with write command
            chk(sd_dq_oe == (wr && k == c), "R8 oe", 32'(sd_dq_oe), 32'(wr && k == c));
            if (wr && k == c) chk(sd_dq_out == data, "R8 write data", sd_dq_out, data);
            if (!wr) begin
                chk(rd_valid == (k == c + CL + 1), "R7 rd_valid timing", 32'(rd_valid),
                    32'(k == c + CL + 1));
                if (k == c + CL + 1) chk(rd_data == edat, "R7 read data", rd_data, edat);
            end
        end
        if (wr) exp_mem[key] = data;
        b_open[bank] = 1'b1; b_row[bank] = row;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < CL; i++) rpipe[i] = '0;
        for (int b = 0; b < 4; b++) mod_row[b] = '0;
        do_reset();

        // Directed: closed-bank write then read hit, conflict in same bank
        run_req(1'b1, 2'd1, 12'h0A5, 8'h10, 32'h11112222);
        run_req(1'b0, 2'd1, 12'h0A5, 8'h10, 32'h0);
        run_req(1'b0, 2'd1, 12'h0A6, 8'hFF, 32'h0);
        // R11: opening bank 2 leaves bank 1 row intact (next bank 1 access hits)
        run_req(1'b1, 2'd2, 12'h001, 8'h00, 32'hABCD0001);
        run_req(1'b0, 2'd1, 12'h0A6, 8'h01, 32'h0);   // R11 expects hit

        // R9: back-to-back same-row writes, one WRITE per cycle
        for (int i = 0; i < 4; i++) begin
            logic [31:0] d;
            d = 32'h5A000000 + 32'(i);
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = {12'h001, 2'd2, 8'(8'h20 + i)}; req_wdata = d;
            #1;
            chk(req_ack == 1'b1, "R9 streamed write ack", 32'(req_ack), 1);
            @(negedge clk);
            chk(cmd == C_WR && sd_dq_out == d && sd_addr == 12'(8'h20 + i),
                "R9 streamed write cmd/data", {cmd, sd_dq_out[27:0]}, {C_WR, d[27:0]});
            exp_mem[{2'd2, 12'h001, 8'(8'h20 + i)}] = d;
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(cmd == C_NOP, "R9 NOP after write run", 32'(cmd), 32'(C_NOP));
        for (int i = 0; i < 4; i++) run_req(1'b0, 2'd2, 12'h001, 8'(8'h20 + i), 32'h0);

        // R1: mid-run reset closes all banks; next access activates
        do_reset();
        @(negedge clk);
        run_req(1'b0, 2'd2, 12'h001, 8'h20, 32'h0);

        // Random mix confined to few rows
        for (int n = 0; n < 300; n++) begin
            logic [1:0] b;
            logic [11:0] r;
            b = 2'($urandom % 4);
            r = 12'($urandom % 3);
            run_req(1'($urandom % 2), b, r, 8'($urandom), $urandom);
        end

        summary();
    end

endmodule